// File: doc/BRIEF.md
# Priority Pin Crossbar Allocator

This block assigns a fixed, ranked set of internal peripheral signals to the pins of a group of 8-bit ports. It has five ports, so 40 pins, by default. Software selects peripheral groups with enable bits. It removes individual pins from allocation with skip bits. A global enable turns routing on. Each enabled signal, taken from the highest rank down, takes the lowest-numbered pin that is neither skipped nor already taken. Any pin left over behaves as general-purpose I/O and is driven from a per-pin output latch.

The block gives out a select code for each pin, along with the pad drive and enable lines. Each pin has a mode bit that chooses push-pull or open-drain drive. Pad input values are routed back to the peripheral that owns each pin. They can also be read directly through a registered pin readback. A compare unit flags when any unmasked pin differs from its match value. An overflow flag reports that more signals are enabled than there are free pins.

Top module: `pin_xbar`

## Requirements
- R1: After reset, every pin select code is 0, `pad_oe` is all zero, and `alloc_ovf`, `port_miss` and `pin_rd` are zero.
- R2: While the registered global enable is clear, `pad_oe` and `pad_do` are all zero and every select code is 0, whatever the other inputs are.
- R3: Signal indices in rank order are: 0-1 UART, 2-3 CAN, 4-7 SPI, 8-9 two-wire serial bus, 10-11 comparator A, 12-13 comparator B, 14 clock out, 15-21 capture/compare channels, 22-25 timer and interrupt inputs, 26-27 LIN. Enabled signals, in index order, take the free pins in ascending pin order. A pin's select code (bits [5p+4:5p] of `pin_sel`) is the index plus 1, and 0 means general-purpose I/O. Each code appears at most once.
- R4: A pin with its `pin_skip` bit set never receives a nonzero select code.
- R5: `grp_en` bit g enables group g in the order of R3 (bit 0 UART through bit 9 LIN). The signals of a cleared group claim no pin.
- R6: `alloc_ovf` is set exactly when routing is enabled and the enabled signals outnumber the non-skipped pins. In that case every free pin is claimed and the excess lowest-ranked signals get none.
- R7: A general-purpose pin with `pin_pp`=1 has `pad_oe`=1 and `pad_do` equal to its `gpio_do` bit. With `pin_pp`=0 it has `pad_oe` equal to the inverse of `gpio_do` and `pad_do`=0.
- R8: A claimed pin follows its signal's `periph_oe` and `periph_do`. Push-pull passes both through. Open-drain drives `pad_oe` only when the signal is enabled and low, with `pad_do`=0.
- R9: `periph_di[s]` equals `pad_in` of the pin that holds signal s, and 1 when signal s holds no pin. The path is combinational.
- R10: `port_miss` is 1 one cycle after `((pad_in ^ match_val) & match_mask)` is nonzero, and 0 one cycle after it is zero.
- R11: `pin_rd` equals `pad_in` from the previous clock edge, whatever the crossbar settings.
- R12: A change on `xbar_en`, `grp_en` or `pin_skip` shows in `pin_sel`, the pad outputs and `alloc_ovf` after exactly one rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xbar_en | input | 1 | Global routing enable |
| grp_en | input | 10 | Peripheral group enables |
| pin_skip | input | 40 | Pins excluded from allocation |
| pin_pp | input | 40 | 1 push-pull, 0 open-drain |
| gpio_do | input | 40 | General-purpose output latch |
| periph_do | input | 28 | Peripheral output values by signal index |
| periph_oe | input | 28 | Peripheral output enables by signal index |
| periph_di | output | 28 | Pin values returned to peripherals |
| pad_in | input | 40 | Pad input values |
| pad_oe | output | 40 | Pad drive enables |
| pad_do | output | 40 | Pad drive values |
| pin_sel | output | 200 | Per-pin 5-bit select codes |
| alloc_ovf | output | 1 | Signals outnumber free pins |
| pin_rd | output | 40 | Registered pad readback |
| match_val | input | 40 | Compare values |
| match_mask | input | 40 | Compare mask |
| port_miss | output | 1 | Registered mismatch flag |

## Verification
Configuration inputs pass through one register, so select codes, pad controls and the overflow flag are due one edge after the configuration changes. The bench drives at the falling edge and samples 1 ns after the next rising edge, and it also samples once before that edge to confirm that the old values still hold. Pad data and the return path through `periph_di` are combinational from the registered selection, so they are checked in the same half-cycle they are driven. The readback and mismatch flag are due one edge after `pad_in` changes and are sampled after that edge.

// File: rtl/pin_xbar_pkg.sv
package pin_xbar_pkg;
  localparam int NGRP = 10;
  localparam int NSIG = 28;
  localparam int SELW = $clog2(NSIG + 1);

  // signals per group, in rank order
  function automatic int grp_width(input int g);
    case (g)
      2, 8:    return 4;
      6:       return 1;
      7:       return 7;
      default: return 2;
    endcase
  endfunction

  function automatic int sig_group(input int s);
    int base;
    base = 0;
    for (int g = 0; g < NGRP; g++) begin
      if (s < base + grp_width(g)) return g;
      base += grp_width(g);
    end
    return NGRP - 1;
  endfunction

  function automatic logic [NSIG-1:0] sig_enables(input logic [NGRP-1:0] ge);
    logic [NSIG-1:0] v;
    for (int s = 0; s < NSIG; s++) v[s] = ge[sig_group(s)];
    return v;
  endfunction
endpackage

// File: rtl/pin_xbar_alloc.sv
module pin_xbar_alloc
  import pin_xbar_pkg::*;
#(
  parameter int NPIN = 40
) (
  input  logic                  en,
  input  logic [NGRP-1:0]       grp_en,
  input  logic [NPIN-1:0]       skip,
  output logic [SELW-1:0]       sel [NPIN],
  output logic                  ovf
);
  logic [NSIG-1:0] sig_on;
  int              free_idx [NPIN];
  int              sig_rank [NSIG];
  int              nfree;
  int              nwant;

  // rank of each free pin and each enabled signal
  always_comb begin
    sig_on = sig_enables(grp_en);
    nfree  = 0;
    for (int p = 0; p < NPIN; p++) begin
      free_idx[p] = nfree;
      if (!skip[p]) nfree = nfree + 1;
    end
    nwant = 0;
    for (int s = 0; s < NSIG; s++) begin
      sig_rank[s] = nwant;
      if (sig_on[s]) nwant = nwant + 1;
    end
  end

  // the r-th enabled signal lands on the r-th free pin
  always_comb begin
    for (int p = 0; p < NPIN; p++) begin
      sel[p] = '0;
      if (en && !skip[p]) begin
        for (int s = 0; s < NSIG; s++) begin
          if (sig_on[s] && sig_rank[s] == free_idx[p]) sel[p] = SELW'(s + 1);
        end
      end
    end
    ovf = en && (nwant > nfree);
  end
endmodule

// File: rtl/pin_xbar_pad.sv
module pin_xbar_pad
  import pin_xbar_pkg::*;
#(
  parameter int NPIN = 40
) (
  input  logic            en,
  input  logic [SELW-1:0] sel [NPIN],
  input  logic [NPIN-1:0] pp,
  input  logic [NPIN-1:0] gpio_do,
  input  logic [NSIG-1:0] periph_do,
  input  logic [NSIG-1:0] periph_oe,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_do,
  output logic [NSIG-1:0] periph_di
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic drv;
    logic act;
    always_comb begin
      drv = gpio_do[p];
      act = 1'b1;
      for (int s = 0; s < NSIG; s++) begin
        if (sel[p] == SELW'(s + 1)) begin
          drv = periph_do[s];
          act = periph_oe[s];
        end
      end
    end
    assign pad_oe[p] = en & (pp[p] ? act : (act & ~drv));
    assign pad_do[p] = en & pp[p] & drv;
  end

  always_comb begin
    periph_di = '1;
    for (int s = 0; s < NSIG; s++) begin
      for (int p = 0; p < NPIN; p++) begin
        if (sel[p] == SELW'(s + 1)) periph_di[s] = pad_in[p];
      end
    end
  end
endmodule

// File: rtl/pin_xbar_match.sv
module pin_xbar_match #(
  parameter int NPIN = 40
) (
  input  logic            clk,
  input  logic            rst_s,
  input  logic [NPIN-1:0] pad_in,
  input  logic [NPIN-1:0] match_val,
  input  logic [NPIN-1:0] match_mask,
  output logic [NPIN-1:0] pin_rd,
  output logic            port_miss
);
  logic miss_d;

  assign miss_d = |((pad_in ^ match_val) & match_mask);

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      pin_rd    <= '0;
      port_miss <= 1'b0;
    end else begin
      pin_rd    <= pad_in;
      port_miss <= miss_d;
    end
  end
endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import pin_xbar_pkg::*;
#(
  parameter int NPORT = 5,
  parameter int PW    = 8,
  localparam int NPIN = NPORT * PW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xbar_en,
  input  logic [NGRP-1:0]      grp_en,
  input  logic [NPIN-1:0]      pin_skip,
  input  logic [NPIN-1:0]      pin_pp,
  input  logic [NPIN-1:0]      gpio_do,
  input  logic [NSIG-1:0]      periph_do,
  input  logic [NSIG-1:0]      periph_oe,
  output logic [NSIG-1:0]      periph_di,
  input  logic [NPIN-1:0]      pad_in,
  output logic [NPIN-1:0]      pad_oe,
  output logic [NPIN-1:0]      pad_do,
  output logic [NPIN*SELW-1:0] pin_sel,
  output logic                 alloc_ovf,
  output logic [NPIN-1:0]      pin_rd,
  input  logic [NPIN-1:0]      match_val,
  input  logic [NPIN-1:0]      match_mask,
  output logic                 port_miss
);
  logic [1:0]      rst_pipe;
  logic            rst_s;
  logic            en_q;
  logic [NGRP-1:0] grp_q;
  logic [NPIN-1:0] skip_q;
  logic            cfg_ce;
  logic [SELW-1:0] sel_w [NPIN];

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  assign cfg_ce = (xbar_en != en_q) || (grp_en != grp_q) || (pin_skip != skip_q);

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      en_q   <= 1'b0;
      grp_q  <= '0;
      skip_q <= '0;
    end else if (cfg_ce) begin
      en_q   <= xbar_en;
      grp_q  <= grp_en;
      skip_q <= pin_skip;
    end
  end

  pin_xbar_alloc #(.NPIN(NPIN)) u_alloc (
    .en     (en_q),
    .grp_en (grp_q),
    .skip   (skip_q),
    .sel    (sel_w),
    .ovf    (alloc_ovf)
  );

  pin_xbar_pad #(.NPIN(NPIN)) u_pad (
    .en        (en_q),
    .sel       (sel_w),
    .pp        (pin_pp),
    .gpio_do   (gpio_do),
    .periph_do (periph_do),
    .periph_oe (periph_oe),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_do    (pad_do),
    .periph_di (periph_di)
  );

  pin_xbar_match #(.NPIN(NPIN)) u_match (
    .clk        (clk),
    .rst_s      (rst_s),
    .pad_in     (pad_in),
    .match_val  (match_val),
    .match_mask (match_mask),
    .pin_rd     (pin_rd),
    .port_miss  (port_miss)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_flat
    assign pin_sel[p*SELW +: SELW] = sel_w[p];
  end
endmodule

// File: rtl/pin_xbar_chk.sv
module pin_xbar_chk
  import pin_xbar_pkg::*;
#(
  parameter int NPIN = 40
) (
  input logic                 clk,
  input logic                 rst_s,
  input logic                 en_q,
  input logic [NGRP-1:0]      grp_q,
  input logic [NPIN-1:0]      skip_q,
  input logic [NPIN*SELW-1:0] pin_sel,
  input logic [NPIN-1:0]      pad_oe,
  input logic                 alloc_ovf,
  input logic                 port_miss,
  input logic [NPIN-1:0]      pin_rd,
  input logic [NPIN-1:0]      pad_in,
  input logic [NPIN-1:0]      match_val,
  input logic [NPIN-1:0]      match_mask
);
  logic [NPIN-1:0] claimed;
  logic            dup;
  int              nclaim;
  int              nwant;
  logic            past_ok;

  always_comb begin
    dup = 1'b0;
    for (int p = 0; p < NPIN; p++) claimed[p] = pin_sel[p*SELW +: SELW] != '0;
    for (int s = 0; s < NSIG; s++) begin
      int c;
      c = 0;
      for (int p = 0; p < NPIN; p++)
        if (pin_sel[p*SELW +: SELW] == SELW'(s + 1)) c = c + 1;
      if (c > 1) dup = 1'b1;
    end
    nclaim = $countones(claimed);
    nwant  = $countones(sig_enables(grp_q));
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_s)
    !en_q |-> (pad_oe == '0 && claimed == '0));
  p_unique_r3: assert property (@(posedge clk) disable iff (!rst_s) !dup);
  p_skip_free_r4: assert property (@(posedge clk) disable iff (!rst_s)
    (claimed & skip_q) == '0);
  p_ovf_full_r6: assert property (@(posedge clk) disable iff (!rst_s)
    alloc_ovf |-> nclaim == $countones(~skip_q));
  p_fit_all_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (en_q && !alloc_ovf) |-> nclaim == nwant);
  p_miss_r10: assert property (@(posedge clk) disable iff (!rst_s)
    past_ok |-> port_miss == |(($past(pad_in) ^ $past(match_val)) & $past(match_mask)));
  p_rd_r11: assert property (@(posedge clk) disable iff (!rst_s)
    past_ok |-> pin_rd == $past(pad_in));
endmodule

bind pin_xbar pin_xbar_chk #(.NPIN(NPIN)) u_chk (
  .clk        (clk),
  .rst_s      (rst_s),
  .en_q       (en_q),
  .grp_q      (grp_q),
  .skip_q     (skip_q),
  .pin_sel    (pin_sel),
  .pad_oe     (pad_oe),
  .alloc_ovf  (alloc_ovf),
  .port_miss  (port_miss),
  .pin_rd     (pin_rd),
  .pad_in     (pad_in),
  .match_val  (match_val),
  .match_mask (match_mask)
);

// File: tb/sim_pin_xbar.sv
module sim_pin_xbar;
  localparam int NPIN = 40;
  localparam int NS   = 28;
  localparam int SW   = 5;
  localparam int NV   = 8;
  // {en, grp_en[9:0], skip[39:0], ovf, claimed count[5:0]}
  localparam logic [57:0] VEC [NV] = '{
    {1'b1, 10'h3FF, 40'h0,          1'b0, 6'd28},
    {1'b1, 10'h001, 40'h1,          1'b0, 6'd2},
    {1'b1, 10'h200, 40'h0,          1'b0, 6'd2},
    {1'b1, 10'h3FF, 40'hFFFF,       1'b1, 6'd24},
    {1'b1, 10'h3FF, 40'hFFF,        1'b0, 6'd28},
    {1'b1, 10'h000, 40'h0,          1'b0, 6'd0},
    {1'b1, 10'h084, 40'h5555555555, 1'b0, 6'd11},
    {1'b0, 10'h3FF, 40'h0,          1'b0, 6'd0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic xbar_en;
  logic [9:0] grp_en;
  logic [NPIN-1:0] pin_skip, pin_pp, gpio_do, pad_in, match_val, match_mask;
  logic [NS-1:0] periph_do, periph_oe, periph_di;
  logic [NPIN-1:0] pad_oe, pad_do, pin_rd;
  logic [NPIN*SW-1:0] pin_sel;
  logic alloc_ovf, port_miss;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pin_xbar u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [199:0] act, input logic [199:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NPIN*SW-1:0] model(input bit en, input logic [9:0] ge, input logic [NPIN-1:0] sk);
    int sizes [10] = '{2, 2, 4, 2, 2, 2, 1, 7, 4, 2};
    int ptr = 0;
    int s = 0;
    logic [NPIN*SW-1:0] r = '0;
    for (int g = 0; g < 10; g++) begin
      for (int k = 0; k < sizes[g]; k++) begin
        if (en && ge[g]) begin
          while (ptr < NPIN && sk[ptr]) ptr++;
          if (ptr < NPIN) begin
            r[ptr*SW +: SW] = SW'(s + 1);
            ptr++;
          end
        end
        s++;
      end
    end
    return r;
  endfunction

  function automatic int nclaim(input logic [NPIN*SW-1:0] v);
    int c = 0;
    for (int p = 0; p < NPIN; p++) if (v[p*SW +: SW] != '0) c++;
    return c;
  endfunction

  function automatic logic [NPIN-1:0] claim_map(input logic [NPIN*SW-1:0] v);
    logic [NPIN-1:0] m;
    for (int p = 0; p < NPIN; p++) m[p] = v[p*SW +: SW] != '0;
    return m;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; xbar_en = 1'b0; grp_en = '0; pin_skip = '0; pin_pp = '1;
    gpio_do = '0; pad_in = '0; match_val = '0; match_mask = '0;
    periph_do = '0; periph_oe = '0;
    repeat (3) tick();
    drive(); rst_n = 1'b1;
    repeat (4) tick();
    // R1 reset state
    chk(pin_sel == '0, "R1 sel", 200'(pin_sel), 0);
    chk(pad_oe == '0, "R1 oe", 200'(pad_oe), 0);
    chk({alloc_ovf, port_miss} == 2'b00 && pin_rd == '0, "R1 flags", {alloc_ovf, port_miss, pin_rd}, 0);

    // vector table: R3 order, R4 skip, R5 group enable, R6 overflow
    for (int i = 0; i < NV; i++) begin
      logic [NPIN*SW-1:0] exp;
      drive();
      {xbar_en, grp_en, pin_skip} = VEC[i][57:7];
      tick();
      exp = model(VEC[i][57], VEC[i][56:47], VEC[i][46:7]);
      chk(pin_sel == exp, "R3 select codes", 200'(pin_sel), 200'(exp));
      chk((claim_map(pin_sel) & pin_skip) == '0, "R4 skip", 200'(claim_map(pin_sel) & pin_skip), 0);
      chk(nclaim(pin_sel) == int'(VEC[i][5:0]), "R5 claimed count", nclaim(pin_sel), VEC[i][5:0]);
      chk(alloc_ovf == VEC[i][6], "R6 overflow", alloc_ovf, VEC[i][6]);
    end

    // R2: disabled means no drive
    drive(); xbar_en = 1'b0; grp_en = 10'h3FF; pin_skip = '0; pin_pp = '1; gpio_do = '1;
    periph_oe = '1; periph_do = '1;
    tick();
    chk(pad_oe == '0 && pad_do == '0, "R2 disabled pads", {pad_oe, pad_do}, 0);

    // R7: general-purpose drive in both modes
    drive(); xbar_en = 1'b1; grp_en = '0;
    pin_pp = 40'hFFFFF00000; gpio_do = 40'hF0F0F0F0F0;
    tick();
    chk(pad_oe == (pin_pp | ~gpio_do), "R7 gpio oe", 200'(pad_oe), 200'(pin_pp | ~gpio_do));
    chk(pad_do == (pin_pp & gpio_do), "R7 gpio do", 200'(pad_do), 200'(pin_pp & gpio_do));

    // R8: UART on pins 0 (open-drain) and 1 (push-pull)
    drive(); grp_en = 10'h001; pin_pp = 40'h2; gpio_do = '0;
    periph_oe = 28'h3; periph_do = 28'h2;
    tick();
    chk(pad_oe[1:0] == 2'b11 && pad_do[1:0] == 2'b10, "R8 periph drive", {pad_oe[1:0], pad_do[1:0]}, 4'b1110);
    drive(); periph_do = 28'h3; #1;
    chk(pad_oe[1:0] == 2'b10, "R8 open-drain release", pad_oe[1:0], 2'b10);

    // R9: input return path
    drive(); pad_in = 40'h2; #1;
    chk(periph_di == 28'hFFFFFFE, "R9 return high", periph_di, 28'hFFFFFFE);
    drive(); pad_in = 40'h0; #1;
    chk(periph_di == 28'hFFFFFFC, "R9 return low", periph_di, 28'hFFFFFFC);

    // R10: mismatch flag
    drive(); match_val = '0; match_mask = 40'h10; pad_in = 40'h10;
    tick();
    chk(port_miss == 1'b1, "R10 mismatch", port_miss, 1);
    drive(); match_mask = 40'h20;
    tick();
    chk(port_miss == 1'b0, "R10 masked", port_miss, 0);

    // R11: readback with crossbar off
    drive(); xbar_en = 1'b0; pad_in = 40'hA5C3_1234_56;
    tick();
    chk(pin_rd == 40'hA5C3_1234_56, "R11 readback", 200'(pin_rd), 200'(40'hA5C3_1234_56));

    // R12: one-edge latency for configuration
    drive(); xbar_en = 1'b1; grp_en = 10'h200; pin_skip = '0; #1;
    chk(pin_sel == '0, "R12 before edge", 200'(pin_sel), 0);
    tick();
    chk(pin_sel[9:0] == {5'd28, 5'd27}, "R12 after edge", pin_sel[9:0], {5'd28, 5'd27});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule